// File: doc/BRIEF.md
# Coarse-Grained Layer Instruction Sequencer

This block sits between an instruction stream and three downstream units of a convolution engine: an input buffer, a processing engine and an output buffer. Each incoming word describes one coarse step of a layer. The block decodes the word and turns it into a series of fine-grained operations. A step can be a single load. It can be a loop of compute operations over the tiles of the output, each optionally followed by a write-back. It can be a loop of write-backs only. Each operation goes out as a request, and the block waits for the matching done pulse.

Instructions arrive on a valid/ready stream. `ins_ready` is high only while the sequencer is idle. A word is taken on the rising edge where `ins_valid` and `ins_ready` are both high. The source may hold `ins_valid` high for as long as it likes, and the word is not consumed until then. Each downstream channel is a level request held high until the unit returns a one-cycle done pulse. Configuration outputs for the engine (bias/zero start, bias shift, bypasses, PE enables, layer kind) and for the output buffer (destination, result shift) are registers. A given group changes only when an instruction that actually uses it is accepted.

Top module: `lyr_instr_seq`

## Requirements
- R1: Out of reset `ins_ready` is 1 and all three requests are 0. `ins_ready` is 1 exactly while no instruction is in progress, and a word is accepted on a clock edge where `ins_valid` and `ins_ready` are both 1.
- R2: Instruction word layout, LSB first (default widths): step kind [1:0] (0 load-only, 1 compute, 2 final, 3 reserved), destination [3:2] (0 none, 1 back to PEs, 2 external memory, 3 reserved), start-from-bias [4], nonlinearity skip [5], pooling skip [6], layer kind [7], PE enable mask [9:8], tile count [13:10], picture count [17:14], bias shift [21:18], result shift [25:22].
- R3: A load-only step issues exactly one load request carrying the word's tile and picture counts, and no compute or write-back.
- R4: A compute step with N>0 tiles issues compute requests for tiles 0..N-1 in order. During all of them the engine configuration outputs equal the word's start-from-bias, nonlinearity skip, pooling skip, layer kind, PE mask and bias shift.
- R5: In a compute step whose destination is 1 or 2, each tile's compute is followed by one write-back of the same tile with that destination and the word's result shift, before the next tile's compute.
- R6: A final step with destination 1 or 2 issues one write-back per tile, in tile order, with no load or compute. With destination 0 or 3 no write-back is issued in any step.
- R7: A step with tile count 0 (compute or final), or with reserved kind 3, retires with no operation issued.
- R8: Each request stays high with a stable tile index until its own done pulse. A done pulse on another channel, or while idle, has no effect.
- R9: Load outputs change only when a load-only step is accepted. Engine configuration changes only when a compute step is accepted. Output-buffer configuration changes only when a compute or final step with destination 1 or 2 is accepted.
- R10: At most one request is high at a time, and no new instruction is accepted until every operation of the current one has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction word valid |
| ins_ready | output | 1 | Sequencer idle, word will be accepted |
| ins_word | input | IW (26) | Instruction word, layout in R2 |
| ld_req | output | 1 | Input-buffer load request |
| ld_done | input | 1 | Load finished pulse |
| ld_tiles | output | TILE_W | Tile count for the load |
| ld_pics | output | PIC_W | Picture count for the load |
| cmp_req | output | 1 | Engine compute request |
| cmp_done | input | 1 | Compute finished pulse |
| cmp_tile | output | TILE_W | Tile being computed |
| cmp_kind | output | 1 | Layer kind |
| cmp_pe_en | output | NPE | PE enable mask |
| cmp_from_bias | output | 1 | Accumulator starts from bias (1) or zero (0) |
| cmp_bias_sh | output | SHW | Bias alignment shift |
| cmp_nl_skip | output | 1 | Bypass the nonlinearity |
| cmp_pool_skip | output | 1 | Bypass pooling |
| wb_req | output | 1 | Output-buffer write-back request |
| wb_done | input | 1 | Write-back finished pulse |
| wb_tile | output | TILE_W | Tile being written back |
| wb_dst | output | 2 | Write-back destination (1 PEs, 2 external memory) |
| wb_res_sh | output | SHW | Result shift |

## Verification
Checked on every cycle: that at most one request is high and none while ready is high, that requests hold with a steady tile index until their own done, that write-backs name a real destination, and that the engine configuration moves only after an accepted compute step. Only the bench's sweeps show that the order and number of operations match each step kind, destination and tile count. The same applies to what each operation carries, to stray done pulses being ignored, and to load-only and final steps leaving unused configuration untouched.

// File: rtl/lis_pkg.sv
package lis_pkg;
  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_COMP  = 2'd1,
    PH_FINAL = 2'd2,
    PH_RSVD  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    WD_NONE = 2'd0,
    WD_PE   = 2'd1,
    WD_EXT  = 2'd2,
    WD_RSVD = 2'd3
  } wdst_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOAD = 2'd1,
    S_CMP  = 2'd2,
    S_WB   = 2'd3
  } seq_st_e;

  // number of single-bit and 2-bit control bits at the bottom of the word
  localparam int CTRL_BITS = 8;

  function automatic logic writes(input wdst_e w);
    return (w == WD_PE) || (w == WD_EXT);
  endfunction
endpackage

// File: rtl/lis_decode.sv
module lis_decode
  import lis_pkg::*;
#(
  parameter int NPE    = 2,
  parameter int TILE_W = 4,
  parameter int PIC_W  = 4,
  parameter int SHW    = 4,
  localparam int IW    = CTRL_BITS + NPE + TILE_W + PIC_W + 2 * SHW
) (
  input  logic [IW-1:0]     word,
  output phase_e            ph,
  output wdst_e             wd,
  output logic              from_bias,
  output logic              nl_skip,
  output logic              pool_skip,
  output logic              kind,
  output logic [NPE-1:0]    pe_en,
  output logic [TILE_W-1:0] tiles,
  output logic [PIC_W-1:0]  pics,
  output logic [SHW-1:0]    bias_sh,
  output logic [SHW-1:0]    res_sh
);
  localparam int P_PE = CTRL_BITS;
  localparam int P_NT = P_PE + NPE;
  localparam int P_NP = P_NT + TILE_W;
  localparam int P_BS = P_NP + PIC_W;
  localparam int P_RS = P_BS + SHW;

  assign ph        = phase_e'(word[1:0]);
  assign wd        = wdst_e'(word[3:2]);
  assign from_bias = word[4];
  assign nl_skip   = word[5];
  assign pool_skip = word[6];
  assign kind      = word[7];
  assign pe_en     = word[P_PE +: NPE];
  assign tiles     = word[P_NT +: TILE_W];
  assign pics      = word[P_NP +: PIC_W];
  assign bias_sh   = word[P_BS +: SHW];
  assign res_sh    = word[P_RS +: SHW];
endmodule

// File: rtl/lis_tile_ctr.sv
module lis_tile_ctr #(
  parameter int TILE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [TILE_W-1:0] limit,
  output logic [TILE_W-1:0] idx,
  output logic              last
);
  always_ff @(posedge clk) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (adv) idx <= idx + TILE_W'(1);
  end

  assign last = (idx == limit - TILE_W'(1));
endmodule

// File: rtl/lis_ctrl.sv
module lis_ctrl
  import lis_pkg::*;
#(
  parameter int TILE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  phase_e            new_ph,
  input  wdst_e             new_wd,
  input  logic [TILE_W-1:0] new_tiles,
  input  logic              ld_done,
  input  logic              cmp_done,
  input  logic              wb_done,
  output logic              idle,
  output logic              ld_req,
  output logic              cmp_req,
  output logic              wb_req,
  output logic [TILE_W-1:0] tile
);
  seq_st_e           st;
  phase_e            cur_ph;
  logic              cur_wr;
  logic [TILE_W-1:0] cur_n;
  logic              last;
  logic              adv;
  logic              new_wr;
  logic              new_some;

  assign new_wr   = writes(new_wd);
  assign new_some = (new_tiles != '0);

  assign adv = (st == S_CMP && cmp_done && !cur_wr && !last) ||
               (st == S_WB  && wb_done  && !last);

  lis_tile_ctr #(.TILE_W(TILE_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .adv   (adv),
    .limit (cur_n),
    .idx   (tile),
    .last  (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cur_ph <= PH_LOAD;
      cur_wr <= 1'b0;
      cur_n  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          cur_ph <= new_ph;
          cur_wr <= new_wr;
          cur_n  <= new_tiles;
          unique case (new_ph)
            PH_LOAD:  st <= S_LOAD;
            PH_COMP:  st <= new_some ? S_CMP : S_IDLE;
            PH_FINAL: st <= (new_some && new_wr) ? S_WB : S_IDLE;
            default:  st <= S_IDLE;
          endcase
        end
        S_LOAD: if (ld_done) st <= S_IDLE;
        S_CMP: if (cmp_done) begin
          if (cur_wr)    st <= S_WB;
          else if (last) st <= S_IDLE;
        end
        S_WB: if (wb_done) begin
          if (last)                    st <= S_IDLE;
          else if (cur_ph == PH_COMP)  st <= S_CMP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign idle    = (st == S_IDLE);
  assign ld_req  = (st == S_LOAD);
  assign cmp_req = (st == S_CMP);
  assign wb_req  = (st == S_WB);
endmodule

// File: rtl/lyr_instr_seq.sv
module lyr_instr_seq
  import lis_pkg::*;
#(
  parameter int NPE    = 2,
  parameter int TILE_W = 4,
  parameter int PIC_W  = 4,
  parameter int SHW    = 4,
  localparam int IW    = CTRL_BITS + NPE + TILE_W + PIC_W + 2 * SHW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [IW-1:0]     ins_word,
  output logic              ld_req,
  input  logic              ld_done,
  output logic [TILE_W-1:0] ld_tiles,
  output logic [PIC_W-1:0]  ld_pics,
  output logic              cmp_req,
  input  logic              cmp_done,
  output logic [TILE_W-1:0] cmp_tile,
  output logic              cmp_kind,
  output logic [NPE-1:0]    cmp_pe_en,
  output logic              cmp_from_bias,
  output logic [SHW-1:0]    cmp_bias_sh,
  output logic              cmp_nl_skip,
  output logic              cmp_pool_skip,
  output logic              wb_req,
  input  logic              wb_done,
  output logic [TILE_W-1:0] wb_tile,
  output logic [1:0]        wb_dst,
  output logic [SHW-1:0]    wb_res_sh
);
  phase_e            d_ph;
  wdst_e             d_wd;
  logic              d_bias, d_nl, d_pool, d_kind;
  logic [NPE-1:0]    d_pe;
  logic [TILE_W-1:0] d_tiles;
  logic [PIC_W-1:0]  d_pics;
  logic [SHW-1:0]    d_bsh, d_rsh;
  logic              idle, accept;
  logic [TILE_W-1:0] tile;

  lis_decode #(.NPE(NPE), .TILE_W(TILE_W), .PIC_W(PIC_W), .SHW(SHW)) u_dec (
    .word      (ins_word),
    .ph        (d_ph),
    .wd        (d_wd),
    .from_bias (d_bias),
    .nl_skip   (d_nl),
    .pool_skip (d_pool),
    .kind      (d_kind),
    .pe_en     (d_pe),
    .tiles     (d_tiles),
    .pics      (d_pics),
    .bias_sh   (d_bsh),
    .res_sh    (d_rsh)
  );

  assign ins_ready = idle;
  assign accept    = ins_valid && idle;

  lis_ctrl #(.TILE_W(TILE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .new_ph    (d_ph),
    .new_wd    (d_wd),
    .new_tiles (d_tiles),
    .ld_done   (ld_done),
    .cmp_done  (cmp_done),
    .wb_done   (wb_done),
    .idle      (idle),
    .ld_req    (ld_req),
    .cmp_req   (cmp_req),
    .wb_req    (wb_req),
    .tile      (tile)
  );

  assign cmp_tile = tile;
  assign wb_tile  = tile;

  // configuration groups: each loads only for a step that uses it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_tiles      <= '0;
      ld_pics       <= '0;
      cmp_kind      <= 1'b0;
      cmp_pe_en     <= '0;
      cmp_from_bias <= 1'b0;
      cmp_bias_sh   <= '0;
      cmp_nl_skip   <= 1'b0;
      cmp_pool_skip <= 1'b0;
      wb_dst        <= 2'd0;
      wb_res_sh     <= '0;
    end else if (accept) begin
      if (d_ph == PH_LOAD) begin
        ld_tiles <= d_tiles;
        ld_pics  <= d_pics;
      end
      if (d_ph == PH_COMP) begin
        cmp_kind      <= d_kind;
        cmp_pe_en     <= d_pe;
        cmp_from_bias <= d_bias;
        cmp_bias_sh   <= d_bsh;
        cmp_nl_skip   <= d_nl;
        cmp_pool_skip <= d_pool;
      end
      if ((d_ph == PH_COMP || d_ph == PH_FINAL) && writes(d_wd)) begin
        wb_dst    <= d_wd;
        wb_res_sh <= d_rsh;
      end
    end
  end
endmodule

// File: rtl/lis_seq_chk.sv
module lis_seq_chk #(
  parameter int TILE_W = 4,
  parameter int SHW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic [1:0]        acc_phase,
  input logic              ld_req,
  input logic              ld_done,
  input logic              cmp_req,
  input logic              cmp_done,
  input logic [TILE_W-1:0] cmp_tile,
  input logic              cmp_from_bias,
  input logic [SHW-1:0]    cmp_bias_sh,
  input logic              wb_req,
  input logic              wb_done,
  input logic [TILE_W-1:0] wb_tile,
  input logic [1:0]        wb_dst
);
  // R10
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_req, cmp_req, wb_req}));

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> !(ld_req || cmp_req || wb_req));

  // R8
  ld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !ld_done) |=> ld_req);

  // R8
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_req && !cmp_done) |=> (cmp_req && $stable(cmp_tile)));

  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_done) |=> (wb_req && $stable(wb_tile) && $stable(wb_dst)));

  // R6
  wb_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (wb_dst == 2'd1 || wb_dst == 2'd2));

  // R9
  cmp_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cmp_bias_sh, cmp_from_bias}) |->
      $past(ins_valid && ins_ready && acc_phase == 2'd1));
endmodule

bind lyr_instr_seq lis_seq_chk #(.TILE_W(TILE_W), .SHW(SHW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ins_valid     (ins_valid),
  .ins_ready     (ins_ready),
  .acc_phase     (ins_word[1:0]),
  .ld_req        (ld_req),
  .ld_done       (ld_done),
  .cmp_req       (cmp_req),
  .cmp_done      (cmp_done),
  .cmp_tile      (cmp_tile),
  .cmp_from_bias (cmp_from_bias),
  .cmp_bias_sh   (cmp_bias_sh),
  .wb_req        (wb_req),
  .wb_done       (wb_done),
  .wb_tile       (wb_tile),
  .wb_dst        (wb_dst)
);

// File: tb/lyr_instr_seq_bench.sv
module lyr_instr_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [25:0] ins_word = '0;
  logic        ld_req, cmp_req, wb_req;
  logic        ld_dr = 0, cmp_dr = 0, wb_dr = 0;
  logic        sp_ld = 0, sp_cmp = 0, sp_wb = 0;
  logic [3:0]  ld_tiles, ld_pics, cmp_tile, wb_tile, cmp_bias_sh, wb_res_sh;
  logic [1:0]  cmp_pe_en, wb_dst;
  logic        cmp_kind, cmp_from_bias, cmp_nl_skip, cmp_pool_skip;

  lyr_instr_seq u_lyr_instr_seq (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_word(ins_word),
    .ld_req(ld_req), .ld_done(ld_dr | sp_ld), .ld_tiles(ld_tiles), .ld_pics(ld_pics),
    .cmp_req(cmp_req), .cmp_done(cmp_dr | sp_cmp), .cmp_tile(cmp_tile),
    .cmp_kind(cmp_kind), .cmp_pe_en(cmp_pe_en), .cmp_from_bias(cmp_from_bias),
    .cmp_bias_sh(cmp_bias_sh), .cmp_nl_skip(cmp_nl_skip), .cmp_pool_skip(cmp_pool_skip),
    .wb_req(wb_req), .wb_done(wb_dr | sp_wb), .wb_tile(wb_tile),
    .wb_dst(wb_dst), .wb_res_sh(wb_res_sh)
  );

  int checks = 0, errors = 0, cyc = 0;
  int lat = 0, cnt = 0;
  int lg_n = 0;
  int lg_k[64], lg_t[64], lg_a[64];
  int ex_n;
  int ex_k[64], ex_t[64], ex_a[64];
  bit bad_rdy = 0;
  int m_ld = 0, m_cmp = 0, m_wb = 0;

  // R2: field positions, MSB first in the concatenation
  function automatic logic [25:0] mk(int ph, int wd, int ub, int nl, int pl, int kd,
                                     int pe, int nt, int np, int bs, int rs);
    return {4'(rs), 4'(bs), 4'(np), 4'(nt), 2'(pe), 1'(kd), 1'(pl), 1'(nl),
            1'(ub), 2'(wd), 2'(ph)};
  endfunction

  function automatic int cpack(int kd, int pe, int ub, int nl, int pl, int bs);
    return kd * 1024 + pe * 256 + ub * 64 + nl * 32 + pl * 16 + bs;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  // downstream units: done after lat cycles of request, log each operation
  always @(negedge clk) begin
    if (ins_ready && (ld_req || cmp_req || wb_req)) bad_rdy = 1;
    if (ld_dr || cmp_dr || wb_dr) begin
      ld_dr = 0; cmp_dr = 0; wb_dr = 0; cnt = 0;
    end else if (ld_req || cmp_req || wb_req) begin
      if (cnt >= lat) begin
        if (lg_n < 64) begin
          if (ld_req) begin
            lg_k[lg_n] = 1; lg_t[lg_n] = 0; lg_a[lg_n] = ld_tiles * 16 + ld_pics;
          end else if (cmp_req) begin
            lg_k[lg_n] = 2; lg_t[lg_n] = cmp_tile;
            lg_a[lg_n] = cpack(cmp_kind, cmp_pe_en, cmp_from_bias, cmp_nl_skip,
                               cmp_pool_skip, cmp_bias_sh);
          end else begin
            lg_k[lg_n] = 3; lg_t[lg_n] = wb_tile; lg_a[lg_n] = wb_dst * 16 + wb_res_sh;
          end
        end
        lg_n++;
        if (ld_req) ld_dr = 1;
        else if (cmp_req) cmp_dr = 1;
        else wb_dr = 1;
      end else cnt++;
    end
  end

  task automatic send(logic [25:0] w);
    int g = 0;
    while (!ins_ready && g < 2000) begin @(negedge clk); g++; end
    lg_n = 0; bad_rdy = 0;
    ins_valid = 1; ins_word = w;
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic wait_done();
    int g = 0;
    while (!(ins_ready && !ld_req && !cmp_req && !wb_req && !ld_dr && !cmp_dr && !wb_dr)
           && g < 2000) begin
      @(negedge clk); g++;
    end
    chk("R10 retire timeout", g < 2000, 1);
  endtask

  task automatic run(int ph, int wd, int ub, int nl, int pl, int kd, int pe,
                     int nt, int np, int bs, int rs);
    bit wr = (wd == 1 || wd == 2);
    string tag;
    ex_n = 0;
    if (ph == 0) begin
      ex_k[0] = 1; ex_t[0] = 0; ex_a[0] = nt * 16 + np; ex_n = 1;
      m_ld = nt * 16 + np;
    end else if (ph == 1) begin
      m_cmp = cpack(kd, pe, ub, nl, pl, bs);
      for (int t = 0; t < nt; t++) begin
        ex_k[ex_n] = 2; ex_t[ex_n] = t; ex_a[ex_n] = m_cmp; ex_n++;
        if (wr) begin ex_k[ex_n] = 3; ex_t[ex_n] = t; ex_a[ex_n] = wd * 16 + rs; ex_n++; end
      end
    end else if (ph == 2 && wr) begin
      for (int t = 0; t < nt; t++) begin
        ex_k[ex_n] = 3; ex_t[ex_n] = t; ex_a[ex_n] = wd * 16 + rs; ex_n++;
      end
    end
    if ((ph == 1 || ph == 2) && wr) m_wb = wd * 16 + rs;
    send(mk(ph, wd, ub, nl, pl, kd, pe, nt, np, bs, rs));
    wait_done();
    tag = (ph == 3 || (ph != 0 && nt == 0)) ? "R7 op count" :
          (ph == 0) ? "R3 op count" : (ph == 1) ? "R5 op count" : "R6 op count";
    chk(tag, lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      tag = (ex_k[i] == 1) ? "R3 load" : (ex_k[i] == 2) ? "R2/R4 compute" :
            (ph == 1) ? "R5 writeback" : "R6 writeback";
      chk({tag, " kind"}, lg_k[i], ex_k[i]);
      chk({tag, " tile"}, lg_t[i], ex_t[i]);
      chk({tag, " fields"}, lg_a[i], ex_a[i]);
    end
    chk("R9 load outputs", ld_tiles * 16 + ld_pics, m_ld);
    chk("R9 engine cfg", cpack(cmp_kind, cmp_pe_en, cmp_from_bias, cmp_nl_skip,
                               cmp_pool_skip, cmp_bias_sh), m_cmp);
    chk("R9 writeback cfg", wb_dst * 16 + wb_res_sh, m_wb);
    chk("R10 ready low while busy", bad_rdy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready in reset", ins_ready, 1);
    chk("R1 no request in reset", ld_req | cmp_req | wb_req, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", ins_ready, 1);

    // R8: stray done pulses while idle change nothing
    sp_ld = 1; sp_cmp = 1; sp_wb = 1;
    @(negedge clk);
    sp_ld = 0; sp_cmp = 0; sp_wb = 0;
    @(negedge clk);
    chk("R8 idle after stray done", ins_ready, 1);
    chk("R8 no request after stray done", ld_req | cmp_req | wb_req, 0);

    // R8: stray done on other channels during a load
    lat = 6;
    send(mk(0, 0, 0, 0, 0, 0, 0, 3, 5, 0, 0));
    sp_cmp = 1; sp_wb = 1;
    @(negedge clk);
    sp_cmp = 0; sp_wb = 0;
    @(negedge clk);
    chk("R8 load still pending", ld_req, 1);
    chk("R8 no other request", cmp_req | wb_req, 0);
    wait_done();
    chk("R8 single load", lg_n, 1);
    m_ld = 3 * 16 + 5;

    // sweep step kind, destination and tile count
    for (int ph = 0; ph < 4; ph++)
      for (int wd = 0; wd < 4; wd++)
        for (int nt = 0; nt < 5; nt++) begin
          int k = ph * 20 + wd * 5 + nt;
          lat = k % 3;
          run(ph, wd, k % 2, (k / 2) % 2, (k / 3) % 2, (k / 5) % 2, (k % 3) + 1,
              nt, (k * 7) % 16, (k * 3) % 16, (k * 5 + 1) % 16);
        end

    // boundary: largest tile count, both destinations
    lat = 0;
    run(1, 1, 1, 0, 1, 1, 3, 15, 9, 15, 15);
    run(2, 2, 0, 1, 0, 0, 2, 15, 1, 2, 7);
    run(0, 3, 1, 1, 1, 1, 3, 15, 15, 15, 15);

    summary();
  end
endmodule